// File: doc/BRIEF.md
# C-bit Loopback Command Detector Bank

This block sits beside a bank of 28 tributary second-order framers. Each framer presents a one-cycle frame strobe together with the three control bits it pulled from that frame. For each port, the block decides whether the far end is sending a line-loopback request. A request frame is one in which the first two control bits agree and the third bit is their inverse.

A per-port persistence filter changes a port's status only after five frames in a row disagree with the current status. This applies in both directions, so a noisy channel cannot toggle the status on a single bad frame. The 28 live status levels are readable as two 16-bit words. A single level interrupt reports that any port is requesting loopback, gated by a mask bit.

In the two modes where the tributaries do not carry this signalling, the block reads as all zeros and keeps its interrupt low. Any change of mode wipes every filter so that each port starts from a clean slate.

Top module: `cbit_lpbk_bank`

## Requirements
- R1: A port's status goes to 1 only after 5 consecutive strobed frames on that port carry a request, where a request means c1 == c2 and c3 != c1.
- R2: A port whose status is 1 returns to 0 only after 5 consecutive strobed frames on that port carry no request.
- R3: A strobed frame that agrees with the current status restarts the run, so an interrupted run of 4 needs a further 5 frames.
- R4: A frame with c1 != c2 counts as a non-request, whatever the value of c3.
- R5: With rd_sel = 0, rd_data bit k is the status of port k, for k = 0..15. With rd_sel = 1, rd_data bit k is the status of port 16+k, for k = 0..11. In that word, bits 15..12 read 0.
- R6: Status is a live level. It changes on the clock edge that samples the completing strobe, and it never changes in a cycle without a strobe on that port.
- R7: irq equals irq_mask AND the OR of all 28 visible status bits.
- R8: The mode encoding is 0 = tributary multiplex, 1 = E3, 2 = G.747, 3 = reserved. In any mode other than 0, rd_data reads 0 and irq is 0, and strobes have no effect.
- R9: A change of mode clears every run counter and every status bit on the next clock edge.
- R10: While rst_n is low, every status bit and run counter is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_stb | input | 28 | One-cycle frame strobe per port |
| c1 | input | 28 | First control bit per port, valid with strobe |
| c2 | input | 28 | Second control bit per port, valid with strobe |
| c3 | input | 28 | Third control bit per port, valid with strobe |
| mode | input | 2 | Operating mode (0 multiplex, 1 E3, 2 G.747, 3 reserved) |
| irq_mask | input | 1 | Interrupt enable |
| rd_sel | input | 1 | Status word select |
| rd_data | output | 16 | Selected status word |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that control bits matter only in a cycle where that port's strobe is high. They also assume that mode is held steady during reset, so the mode register starts equal to the live mode. The bench drives every strobe for exactly one clock, between falling edges, and changes mode only on a falling edge. It keeps mode at 0 through every reset, which satisfies both assumptions.

// File: rtl/cbit_lpbk_pkg.sv
package cbit_lpbk_pkg;
  typedef enum logic [1:0] {
    LM_MUX  = 2'd0,
    LM_E3   = 2'd1,
    LM_G747 = 2'd2,
    LM_RSVD = 2'd3
  } lpbk_mode_e;

  localparam int unsigned DEF_PORTS   = 28;
  localparam int unsigned DEF_WORD_W  = 16;
  localparam int unsigned DEF_RUN_LEN = 5;
endpackage

// File: rtl/cbit_persist_filter.sv
module cbit_persist_filter #(
  parameter int unsigned RUN_LEN = 5,
  localparam int unsigned CNT_W  = $clog2(RUN_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic frame_en,
  input  logic c1,
  input  logic c2,
  input  logic c3,
  output logic status
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stat_q, stat_d;
  logic             req_frame;

  assign req_frame = (c1 == c2) && (c3 != c1);

  always_comb begin
    cnt_d  = cnt_q;
    stat_d = stat_q;
    if (clr) begin
      cnt_d  = '0;
      stat_d = 1'b0;
    end else if (frame_en) begin
      if (req_frame == stat_q) begin
        cnt_d = '0;
      end else if (cnt_q == CNT_W'(RUN_LEN - 1)) begin
        cnt_d  = '0;
        stat_d = ~stat_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      stat_q <= stat_d;
    end
  end

  assign status = stat_q;
endmodule

// File: rtl/cbit_status_pack.sv
module cbit_status_pack #(
  parameter int unsigned NPORTS = 28,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned NWORDS = (NPORTS + WORD_W - 1) / WORD_W,
  localparam int unsigned SEL_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int unsigned PAD_W  = NWORDS * WORD_W
) (
  input  logic [NPORTS-1:0] stat_vec,
  input  logic              active,
  input  logic              irq_mask,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq
);
  logic [PAD_W-1:0]  padded;
  logic [WORD_W-1:0] words [NWORDS];

  for (genvar b = 0; b < PAD_W; b++) begin : g_pad
    if (b < NPORTS) begin : g_live
      assign padded[b] = stat_vec[b] & active;
    end else begin : g_zero
      assign padded[b] = 1'b0;
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign words[w] = padded[w*WORD_W +: WORD_W];
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (rd_sel == SEL_W'(w)) rd_data = words[w];
    end
  end

  assign irq = irq_mask & (|padded);
endmodule

// File: rtl/cbit_lpbk_bank.sv
module cbit_lpbk_bank #(
  parameter int unsigned NPORTS  = cbit_lpbk_pkg::DEF_PORTS,
  parameter int unsigned WORD_W  = cbit_lpbk_pkg::DEF_WORD_W,
  parameter int unsigned RUN_LEN = cbit_lpbk_pkg::DEF_RUN_LEN,
  localparam int unsigned NWORDS = (NPORTS + WORD_W - 1) / WORD_W,
  localparam int unsigned SEL_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] frame_stb,
  input  logic [NPORTS-1:0] c1,
  input  logic [NPORTS-1:0] c2,
  input  logic [NPORTS-1:0] c3,
  input  logic [1:0]        mode,
  input  logic              irq_mask,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq
);
  import cbit_lpbk_pkg::*;

  logic [1:0]        mode_q, mode_d;
  logic              active;
  logic              clr_all;
  logic [NPORTS-1:0] stat_vec;

  assign active  = (mode == LM_MUX);
  assign clr_all = (mode != mode_q) || !active;
  assign mode_d  = mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= LM_MUX;
    else        mode_q <= mode_d;
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    cbit_persist_filter #(.RUN_LEN(RUN_LEN)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_all),
      .frame_en (frame_stb[p]),
      .c1       (c1[p]),
      .c2       (c2[p]),
      .c3       (c3[p]),
      .status   (stat_vec[p])
    );
  end

  cbit_status_pack #(.NPORTS(NPORTS), .WORD_W(WORD_W)) u_pack (
    .stat_vec (stat_vec),
    .active   (active),
    .irq_mask (irq_mask),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .irq      (irq)
  );
endmodule

// File: rtl/cbit_lpbk_chk.sv
module cbit_lpbk_chk #(
  parameter int unsigned NPORTS = 28,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SEL_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORTS-1:0] frame_stb,
  input logic [1:0]        mode,
  input logic              irq_mask,
  input logic [SEL_W-1:0]  rd_sel,
  input logic [WORD_W-1:0] rd_data,
  input logic              irq,
  input logic [NPORTS-1:0] stat_vec
);
  // R8: outside multiplex mode nothing is visible
  a_r8_quiet_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0) |-> (rd_data == '0 && !irq));

  // R5: unused top bits of the last word stay low
  a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_W'(1)) |-> (rd_data[WORD_W-1:NPORTS-WORD_W] == '0));

  // R7: no interrupt while masked
  a_r7_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> !irq);

  // R6: no strobe and steady mode leave all status untouched
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb == '0 && $stable(mode)) |=> $stable(stat_vec));

  for (genvar p = 0; p < NPORTS; p++) begin : g_rise
    // R1: a status only rises on a sampled frame of its own port
    a_r1_rise_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_vec[p]) |-> $past(frame_stb[p]));
  end
endmodule

bind cbit_lpbk_bank cbit_lpbk_chk #(.NPORTS(NPORTS), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_stb (frame_stb),
  .mode      (mode),
  .irq_mask  (irq_mask),
  .rd_sel    (rd_sel),
  .rd_data   (rd_data),
  .irq       (irq),
  .stat_vec  (stat_vec)
);

// File: tb/tb_cbit_lpbk_bank.sv
module tb_cbit_lpbk_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] frame_stb = '0, c1 = '0, c2 = '0, c3 = '0;
  logic [1:0]    mode = 2'd0;
  logic          irq_mask = 1'b0;
  logic          rd_sel = 1'b0;
  logic [15:0]   rd_data;
  logic          irq;

  int checks = 0;
  int errors = 0;
  logic [NP-1:0] exp_st = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbit_lpbk_bank dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .c1(c1), .c2(c2), .c3(c3),
    .mode(mode), .irq_mask(irq_mask), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  // entry: {port[4:0], {c1,c2,c3}, expected status after frame}
  localparam logic [8:0] VEC [29] = '{
    {5'd0, 3'b001, 1'b0}, {5'd0, 3'b001, 1'b0}, {5'd0, 3'b001, 1'b0},
    {5'd0, 3'b001, 1'b0}, {5'd0, 3'b001, 1'b1},   // R1 set on 5th
    {5'd0, 3'b110, 1'b1},                        // R3 request keeps it
    {5'd0, 3'b000, 1'b1}, {5'd0, 3'b000, 1'b1},
    {5'd0, 3'b011, 1'b1},                        // R4 c1!=c2 is non-request
    {5'd0, 3'b000, 1'b1}, {5'd0, 3'b111, 1'b0},   // R2 clear on 5th
    {5'd0, 3'b001, 1'b0}, {5'd0, 3'b001, 1'b0}, {5'd0, 3'b001, 1'b0},
    {5'd0, 3'b001, 1'b0}, {5'd0, 3'b000, 1'b0},   // R3 broken run of 4
    {5'd0, 3'b001, 1'b0}, {5'd0, 3'b001, 1'b0}, {5'd0, 3'b001, 1'b0},
    {5'd0, 3'b001, 1'b0}, {5'd0, 3'b001, 1'b1},
    {5'd27, 3'b110, 1'b0}, {5'd27, 3'b110, 1'b0}, {5'd27, 3'b110, 1'b0},
    {5'd27, 3'b101, 1'b0},                        // R4 restarts run
    {5'd27, 3'b110, 1'b0}, {5'd27, 3'b110, 1'b0}, {5'd27, 3'b110, 1'b0},
    {5'd27, 3'b110, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic check_words(input string req);
    rd_sel = 1'b0; #1;
    chk(req, 32'(rd_data), 32'(exp_st[15:0]));
    rd_sel = 1'b1; #1;
    chk(req, 32'(rd_data), {20'd0, exp_st[27:16]});
  endtask

  task automatic send(input int p, input logic [2:0] c);
    @(negedge clk);
    frame_stb[p] = 1'b1; c1[p] = c[2]; c2[p] = c[1]; c3[p] = c[0];
    @(negedge clk);
    frame_stb = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_words("R10 reset state");
    chk("R10 reset irq", 32'(irq), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 29; i++) begin
      send(int'(VEC[i][8:4]), VEC[i][3:1]);
      exp_st[VEC[i][8:4]] = VEC[i][0];
      check_words("R1 R2 R3 R4 table");
    end
    // last port-27 frame completes a run of 5 after the restart
    send(27, 3'b110);
    exp_st[27] = 1'b1;
    check_words("R5 port 27 in second word bit 11");
    rd_sel = 1'b1; #1;
    chk("R5 upper bits zero", 32'(rd_data[15:12]), 0);

    // R6 idle cycles change nothing
    repeat (10) @(negedge clk);
    check_words("R6 idle hold");

    // R7 interrupt masking
    irq_mask = 1'b0; #1;
    chk("R7 masked irq", 32'(irq), 0);
    irq_mask = 1'b1; #1;
    chk("R7 unmasked irq", 32'(irq), 1);

    // R6 timing: the 5th frame shows only after its edge
    for (int k = 0; k < 4; k++) send(9, 3'b001);
    @(negedge clk);
    frame_stb[9] = 1'b1; c1[9] = 1'b0; c2[9] = 1'b0; c3[9] = 1'b1;
    rd_sel = 1'b0; #1;
    chk("R6 before edge", 32'(rd_data[9]), 0);
    @(negedge clk);
    frame_stb = '0;
    exp_st[9] = 1'b1;
    check_words("R6 after edge");

    // R8 E3 mode hides everything and ignores frames
    @(negedge clk);
    mode = 2'd1; #1;
    rd_sel = 1'b0; #1;
    chk("R8 E3 word0", 32'(rd_data), 0);
    rd_sel = 1'b1; #1;
    chk("R8 E3 word1", 32'(rd_data), 0);
    chk("R8 E3 irq", 32'(irq), 0);
    for (int k = 0; k < 5; k++) send(3, 3'b001);
    rd_sel = 1'b0; #1;
    chk("R8 E3 frames ignored", 32'(rd_data), 0);

    // R9 back to multiplex mode: all cleared
    @(negedge clk);
    mode = 2'd0;
    @(negedge clk);
    exp_st = '0;
    check_words("R9 cleared after mode change");
    chk("R9 irq low", 32'(irq), 0);

    // R9 a partial run is wiped by a mode change
    for (int k = 0; k < 4; k++) send(5, 3'b001);
    @(negedge clk); mode = 2'd2;
    @(negedge clk); mode = 2'd0;
    @(negedge clk);
    send(5, 3'b001);
    check_words("R9 run restarted");
    for (int k = 0; k < 3; k++) send(5, 3'b001);
    check_words("R9 four after clear");
    send(5, 3'b001);
    exp_st[5] = 1'b1;
    check_words("R9 five after clear");
    chk("R7 irq with port 5", 32'(irq), 1);

    // R10 asynchronous reset mid-run
    #2;
    rst_n = 1'b0; #1;
    exp_st = '0;
    check_words("R10 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    check_words("R10 after release");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule